// File: doc/BRIEF.md
# Interrupt Source Coalescing State Controller

This block keeps a two-bit record for every interrupt source it serves. The high bit (P) says that the source has already been handed to the event queue and is waiting for its end-of-interrupt. The low bit (Q) says that a further trigger arrived while P was set. A trigger from a source therefore produces at most one queue entry until software acknowledges it. Any trigger that arrives before the acknowledgement is remembered in Q and replayed when the acknowledgement comes.

Software reaches the state through a memory-mapped request port. Every source owns a 4 KiB page: the address bits above bit 11 select the source, and the offset inside the page selects what happens. A load can return the state, acknowledge the source, or force a new state. In every case it returns the value the two bits held before the access. A store can also acknowledge the source. When a source must be queued, the block raises a notify strobe together with the source number. A small fixed-priority stage sends out one such event per cycle.

Top module: `irq_pq_ctrl`

## Requirements
- R1: After synchronous reset every source holds state 01 (P=0, Q=1, masked), `notify_valid` is low and `rsp_valid` is low.
- R2: A load at page offset 0x800 returns the state with P at bit 1 and Q at bit 0, zero-extended to 64 bits, and leaves the state unchanged. Each load's `rsp_valid`/`rsp_data` appear in the cycle after the request edge.
- R3: A trigger on a source in state 00 moves it to 10 and queues one notify for that source.
- R4: A trigger on a source whose P bit is set moves it to 11 and queues nothing.
- R5: A trigger on a source in state 01 leaves it at 01 and queues nothing.
- R6: A load at offset 0x000 is an end-of-interrupt and returns the prior state. If Q was 0, the state becomes 00. If Q was 1, the state becomes 10 and one notify is queued.
- R7: When `STORE_EOI_EN` is 1, a store at offset 0x400 acts as an end-of-interrupt. A store never produces a response, and a store at any other offset changes nothing.
- R8: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 and return the prior state.
- R9: When an access and a trigger hit the same source in one cycle, the access is applied first and the trigger is then applied to the resulting state.
- R10: A load at any other offset, or to a page whose source number is at least `N_SRC`, returns 0 and changes no state.
- R11: Each queued notify leaves on `notify_valid`/`notify_idx` exactly once. It is visible from the edge after the one that queued it, at most one per cycle, and the lowest pending source number goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address: source page in bits above 11, offset in bits 11:0 |
| trig | input | N_SRC | Per-source trigger pulses |
| rsp_valid | output | 1 | Load response strobe |
| rsp_data | output | 64 | Prior state of the addressed source, P at bit 1, Q at bit 0 |
| notify_valid | output | 1 | A source is being sent to the event queue |
| notify_idx | output | $clog2(N_SRC) | Number of the source being sent |

## Verification
A load response is registered, so it is checked one clock after the edge that accepts the request. The bench drives on the falling edge and samples on the next falling edge. A trigger or acknowledgement that queues a source also shows on the notify outputs after one edge, so the same sample covers it. When several sources queue at once, later ones come out one cycle apart, and the bench samples those notifies on consecutive falling edges. Changes of state that produce no output are read back through a state-read load in the following step.

// File: rtl/irq_pq_pkg.sv
// Package: shared types for the interrupt coalescing controller.
// Assumes a 12-bit page offset per source.
package irq_pq_pkg;
    localparam int PAGE_BITS = 12;

    // Encoded two-bit source states, P in bit 1, Q in bit 0
    localparam logic [1:0] ST_IDLE = 2'b00;
    localparam logic [1:0] ST_MASK = 2'b01;
    localparam logic [1:0] ST_PEND = 2'b10;
    localparam logic [1:0] ST_PEND_AGAIN = 2'b11;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_GET  = 2'd1,
        OP_EOI  = 2'd2,
        OP_SET  = 2'd3
    } pq_op_t;
endpackage

// File: rtl/irq_pq_decode.sv
// Module: irq_pq_decode
// Turns a request's direction and page offset into a state operation.
// Assumes offset is the low PAGE_BITS of the address. Unsupported
// combinations decode to OP_NONE.
module irq_pq_decode
    import irq_pq_pkg::*;
#(
    parameter bit STORE_EOI_EN = 1'b1
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [PAGE_BITS-1:0] offset,
    output pq_op_t               op,
    output logic [1:0]           set_val
);
    // Match the offset against the supported operation slots
    always_comb begin
        op      = OP_NONE;
        set_val = offset[9:8];
        if (req_valid) begin
            if (req_write) begin
                if (STORE_EOI_EN && offset == 12'h400) op = OP_EOI;
            end else begin
                case (offset)
                    12'h000: op = OP_EOI;
                    12'h800: op = OP_GET;
                    12'hC00, 12'hD00, 12'hE00, 12'hF00: op = OP_SET;
                    default: op = OP_NONE;
                endcase
            end
        end
    end

    // Nothing is decoded without a request (R10)
    always_comb begin
        if (!req_valid) assert_idle_decode_R10: assert (op == OP_NONE);
    end
endmodule

// File: rtl/irq_pq_cell.sv
// Module: irq_pq_cell
// State of one interrupt source. Applies the access operation first and
// then the trigger (R9). Raises fire when the source must be queued.
// Assumes op is OP_NONE unless this source is addressed.
module irq_pq_cell
    import irq_pq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pq_op_t     op,
    input  logic [1:0] set_val,
    input  logic       trig,
    output logic [1:0] st_q,
    output logic       fire
);
    logic [1:0] mid_st;
    logic [1:0] nxt_st;
    logic       eoi_fire;
    logic       trig_fire;

    // Step 1: the access operation on the current state
    always_comb begin
        mid_st   = st_q;
        eoi_fire = 1'b0;
        case (op)
            OP_EOI: begin
                if (st_q[0]) begin
                    mid_st   = ST_PEND;
                    eoi_fire = 1'b1;
                end else begin
                    mid_st = ST_IDLE;
                end
            end
            OP_SET:  mid_st = set_val;
            default: mid_st = st_q;
        endcase
    end

    // Step 2: the trigger evaluated against the post-access state
    always_comb begin
        nxt_st    = mid_st;
        trig_fire = 1'b0;
        if (trig) begin
            case (mid_st)
                ST_IDLE: begin
                    nxt_st    = ST_PEND;
                    trig_fire = 1'b1;
                end
                ST_PEND, ST_PEND_AGAIN: nxt_st = ST_PEND_AGAIN;
                default: nxt_st = mid_st;
            endcase
        end
        fire = eoi_fire | trig_fire;
    end

    // State register, reset to masked
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_MASK;
        else        st_q <= nxt_st;
    end

    assert_idle_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && trig && st_q == ST_IDLE) |=> st_q == ST_PEND);
    assert_pending_coalesce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && trig && st_q[1]) |=> st_q == ST_PEND_AGAIN);
    assert_masked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && trig && st_q == ST_MASK) |=> st_q == ST_MASK);
    assert_eoi_refire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EOI && st_q[0] && !trig) |=> st_q == ST_PEND);
    assert_get_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_GET && !trig) |=> $stable(st_q));
endmodule

// File: rtl/irq_pq_notify.sv
// Module: irq_pq_notify
// Holds one pending flag per source and sends one queue event per cycle,
// lowest source number first. A flag raised while set stays a single event.
module irq_pq_notify #(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] fire,
    output logic             notify_valid,
    output logic [IDX_W-1:0] notify_idx
);
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] grant;

    // Fixed-priority pick of the lowest pending source
    always_comb begin
        grant      = '0;
        notify_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant      = '0;
                grant[i]   = 1'b1;
                notify_idx = IDX_W'(i);
            end
        end
        notify_valid = |pend_q;
    end

    // Pending flags: drop the granted one, add new fires
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~grant) | fire;
    end

    assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> pend_q[notify_idx]);
    assert_grant_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_valid && !fire[notify_idx]) |=> !pend_q[$past(notify_idx)]);
endmodule

// File: rtl/irq_pq_ctrl.sv
// Module: irq_pq_ctrl (top)
// Per-source P/Q coalescing state with a paged access port and a
// notify output. Assumes ADDR_W >= PAGE_BITS + $clog2(N_SRC) and N_SRC >= 2.
module irq_pq_ctrl
    import irq_pq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int ADDR_W = 16,
    parameter bit STORE_EOI_EN = 1'b1,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [N_SRC-1:0]  trig,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              notify_valid,
    output logic [IDX_W-1:0]  notify_idx
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_W-1:0]          page;
    logic [IDX_W-1:0]           sel;
    logic                       in_range;
    pq_op_t                     dec_op;
    logic [1:0]                 set_val;
    logic [N_SRC-1:0][1:0]      st_all;
    logic [N_SRC-1:0]           fire;
    logic                       is_load;

    // Address split into source page and in-page offset
    always_comb begin
        page     = req_addr[ADDR_W-1:PAGE_BITS];
        sel      = page[IDX_W-1:0];
        in_range = int'(page) < N_SRC;
        is_load  = req_valid && !req_write;
    end

    irq_pq_decode #(.STORE_EOI_EN(STORE_EOI_EN)) u_decode (
        .req_valid (req_valid && in_range),
        .req_write (req_write),
        .offset    (req_addr[PAGE_BITS-1:0]),
        .op        (dec_op),
        .set_val   (set_val)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        pq_op_t cell_op;

        // Route the operation only to the addressed source
        always_comb begin
            cell_op = (sel == IDX_W'(g)) ? dec_op : OP_NONE;
        end

        irq_pq_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (cell_op),
            .set_val (set_val),
            .trig    (trig[g]),
            .st_q    (st_all[g]),
            .fire    (fire[g])
        );
    end

    irq_pq_notify #(.N_SRC(N_SRC)) u_notify (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .notify_valid (notify_valid),
        .notify_idx   (notify_idx)
    );

    // Load response register: prior state for supported loads, else zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= is_load;
            rsp_data  <= '0;
            if (is_load && dec_op != OP_NONE) rsp_data <= {62'd0, st_all[sel]};
        end
    end

    assert_rsp_follows_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> rsp_valid);
    assert_no_rsp_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_load |=> !rsp_valid);
    assert_bad_page_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && !in_range) |=> rsp_data == 64'd0);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data[63:2] == '0);
endmodule

// File: tb/irq_pq_ctrl_tb.sv
module irq_pq_ctrl_tb;
    localparam int N = 8;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [N-1:0] trig = '0;
    logic rsp_valid;
    logic [63:0] rsp_data;
    logic notify_valid;
    logic [2:0] notify_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_pq_ctrl #(.N_SRC(N), .ADDR_W(AW), .STORE_EOI_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .trig(trig), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .notify_valid(notify_valid), .notify_idx(notify_idx)
    );

    // kind: 0 none, 1 load, 2 store
    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] off;
        logic [3:0]  src;
        logic [7:0]  tg;
        logic [1:0]  exp;
        logic        nv;
        logic [2:0]  idx;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 23;
    localparam step_t TBL [NSTEP] = '{
        '{2'd1, 12'h800, 4'd0, 8'h00, 2'b01, 1'b0, 3'd0, 8'd1},  // R1 reset state
        '{2'd0, 12'h000, 4'd0, 8'h01, 2'b00, 1'b0, 3'd0, 8'd5},  // R5 masked trigger
        '{2'd1, 12'h800, 4'd0, 8'h00, 2'b01, 1'b0, 3'd0, 8'd5},
        '{2'd1, 12'hC00, 4'd0, 8'h00, 2'b01, 1'b0, 3'd0, 8'd8},  // R8 set 00
        '{2'd0, 12'h000, 4'd0, 8'h01, 2'b00, 1'b1, 3'd0, 8'd3},  // R3 idle trigger
        '{2'd0, 12'h000, 4'd0, 8'h01, 2'b00, 1'b0, 3'd0, 8'd4},  // R4 coalesce
        '{2'd1, 12'h800, 4'd0, 8'h00, 2'b11, 1'b0, 3'd0, 8'd4},
        '{2'd1, 12'h000, 4'd0, 8'h00, 2'b11, 1'b1, 3'd0, 8'd6},  // R6 eoi refire
        '{2'd1, 12'h800, 4'd0, 8'h00, 2'b10, 1'b0, 3'd0, 8'd6},
        '{2'd1, 12'h000, 4'd0, 8'h00, 2'b10, 1'b0, 3'd0, 8'd6},  // R6 eoi clear
        '{2'd1, 12'hE00, 4'd3, 8'h00, 2'b01, 1'b0, 3'd0, 8'd8},  // R8 set 10
        '{2'd1, 12'h800, 4'd3, 8'h00, 2'b10, 1'b0, 3'd0, 8'd2},  // R2 get
        '{2'd1, 12'h100, 4'd3, 8'h00, 2'b00, 1'b0, 3'd0, 8'd10}, // R10 bad offset
        '{2'd1, 12'h800, 4'd3, 8'h00, 2'b10, 1'b0, 3'd0, 8'd10},
        '{2'd1, 12'hC00, 4'd5, 8'h20, 2'b01, 1'b1, 3'd5, 8'd9},  // R9 set then trigger
        '{2'd1, 12'h800, 4'd5, 8'h00, 2'b10, 1'b0, 3'd0, 8'd9},
        '{2'd2, 12'h400, 4'd5, 8'h00, 2'b00, 1'b0, 3'd0, 8'd7},  // R7 store eoi
        '{2'd1, 12'h800, 4'd5, 8'h00, 2'b00, 1'b0, 3'd0, 8'd7},
        '{2'd1, 12'hD00, 4'd5, 8'h00, 2'b00, 1'b0, 3'd0, 8'd8},  // R8 set 01
        '{2'd1, 12'h800, 4'd5, 8'h00, 2'b01, 1'b0, 3'd0, 8'd8},
        '{2'd1, 12'hF00, 4'd2, 8'h00, 2'b01, 1'b0, 3'd0, 8'd8},  // R8 set 11
        '{2'd1, 12'h000, 4'd2, 8'h04, 2'b11, 1'b1, 3'd2, 8'd9},  // R9 eoi then trigger
        '{2'd1, 12'h800, 4'd2, 8'h00, 2'b11, 1'b0, 3'd0, 8'd9}
    };

    task automatic check(input bit ok, input int rq, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Drive one step at a falling edge; the result is sampled one edge later
    task automatic drive(input logic [1:0] kind, input logic [11:0] off,
                         input logic [3:0] src, input logic [7:0] tg);
        req_valid = (kind != 2'd0);
        req_write = (kind == 2'd2);
        req_addr  = {src, off};
        trig      = tg;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        trig      = '0;
    endtask

    task automatic check_notify(input int rq, input logic nv, input logic [2:0] idx);
        check(notify_valid == nv, rq, 64'(notify_valid), 64'(nv));
        if (nv) check(notify_idx == idx, rq, 64'(notify_idx), 64'(idx));
    endtask

    task automatic get_check(input int rq, input logic [3:0] src, input logic [1:0] exp);
        drive(2'd1, 12'h800, src, 8'h00);
        check(rsp_valid && rsp_data == 64'(exp), rq, rsp_data, 64'(exp));
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        check(!rsp_valid, 1, 64'(rsp_valid), 64'd0);
        check(!notify_valid, 1, 64'(notify_valid), 64'd0);
        get_check(1, 4'd7, 2'b01);   // R1 masked state on the last source

        for (int i = 0; i < NSTEP; i++) begin
            drive(TBL[i].kind, TBL[i].off, TBL[i].src, TBL[i].tg);
            check(rsp_valid == (TBL[i].kind == 2'd1), int'(TBL[i].req),
                  64'(rsp_valid), 64'(TBL[i].kind == 2'd1));
            if (TBL[i].kind == 2'd1)
                check(rsp_data == 64'(TBL[i].exp), int'(TBL[i].req),
                      rsp_data, 64'(TBL[i].exp));
            check_notify(int'(TBL[i].req), TBL[i].nv, TBL[i].idx);
        end

        // R10: page beyond the last source reads zero
        drive(2'd1, 12'h800, 4'd9, 8'h00);
        check(rsp_valid && rsp_data == 64'd0, 10, rsp_data, 64'd0);

        // R11: two sources queued in one cycle leave lowest first, one per cycle
        drive(2'd1, 12'hC00, 4'd1, 8'h00);
        drive(2'd1, 12'hC00, 4'd6, 8'h00);
        drive(2'd0, 12'h000, 4'd0, 8'b0100_0010);
        check_notify(11, 1'b1, 3'd1);
        @(negedge clk);
        check_notify(11, 1'b1, 3'd6);
        @(negedge clk);
        check_notify(11, 1'b0, 3'd0);

        // R7: a store at a set offset is ignored and gets no response
        drive(2'd2, 12'hC00, 4'd6, 8'h00);
        check(!rsp_valid, 7, 64'(rsp_valid), 64'd0);
        get_check(7, 4'd6, 2'b10);

        // R4: a pending source that is triggered again queues no second event
        drive(2'd0, 12'h000, 4'd0, 8'b0000_0010);
        check_notify(4, 1'b0, 3'd0);
        get_check(4, 4'd1, 2'b11);

        finish_run();
    end
endmodule